// File: doc/BRIEF.md
# Per-Block Three-Level Lock Manager

This block holds the write-protection state of an array of erase blocks and decides, one request at a time, whether a program or erase aimed at a block may go ahead. Software changes the state with two-write command sequences on a simple bus-write port that carries a block address and an 8-bit command byte. Each block has a locked bit and a locked-down bit. A write-protect pin, active low, decides whether the locked-down bit can be overridden.

A block that is locked refuses program and erase. A block that is locked down is treated as locked for as long as the write-protect pin is low, and no command can unlock it then. With the pin high, the same block can be unlocked like any other block, but its locked-down bit stays set, so it falls back to locked as soon as the pin goes low again. Only reset clears the locked-down bits. A status read mode lets the lock state of any queried block be read back. The status logic receives one-cycle pulses for refused requests and for malformed command sequences.

Top module: `blk_lock_mgr`

## Requirements
- R1: After reset every block reads as locked (status 2'b01) and not locked down, and the block is in array read mode (sig_mode_o = 0, status_o = 0).
- R2: The write 60h followed by the write 01h locks the block addressed by the second write and no other block. The new state is visible on status_o in the cycle after that second write.
- R3: The write 60h followed by the write D0h unlocks the addressed block, unless R5 applies.
- R4: The write 60h followed by the write 2Fh sets both the locked bit and the locked-down bit of the addressed block (status 2'b11).
- R5: While wp_ni is low, an unlock sequence aimed at a locked-down block leaves it locked.
- R6: While wp_ni is high, a locked-down block can be unlocked. Its status then reads 2'b10 and requests to it are permitted. When wp_ni goes low, the block reads 2'b11 again and requests to it are refused, with no clock edge needed.
- R7: No command clears a locked-down bit. Only reset does.
- R8: If the write after 60h is not 01h, D0h or 2Fh, seq_err_o is high for exactly one cycle after that write. No lock state changes, and the decoder returns to idle, so a following 01h write has no effect.
- R9: The write 90h enters status read mode (sig_mode_o = 1), in which status_o = {locked-down, effective locked} of query_blk_i. The write FFh returns to array mode, in which status_o = 0.
- R10: req_permit_o is high in the same cycle as req_valid_i when the requested block is not effectively locked. A refused request sets prot_err_o for exactly the next cycle.
- R11: A write outside a sequence whose byte is not 60h, 90h or FFh changes no state and no mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Bus write strobe |
| wr_addr_i | input | BLK_W | Block index of the bus write |
| wr_data_i | input | 8 | Command byte |
| wp_ni | input | 1 | Write protect, active low |
| query_blk_i | input | BLK_W | Block whose state status_o reports |
| status_o | output | 2 | {locked-down, effective locked} in status read mode, else 0 |
| sig_mode_o | output | 1 | High while in status read mode |
| req_valid_i | input | 1 | Program or erase request strobe |
| req_blk_i | input | BLK_W | Target block of the request |
| req_permit_o | output | 1 | Request allowed |
| prot_err_o | output | 1 | Pulse one cycle after a refused request |
| seq_err_o | output | 1 | Pulse one cycle after a malformed lock sequence |

## Verification
On every cycle the assertions check four things. Locked-down bits never fall outside reset. A locked-down block stays locked through any cycle in which write protect is low. The locked-down bit never rises without the locked bit. The error pulses only follow the conditions that justify them, and a permit never appears without a request. The bench scenarios are needed to show what the command sequences do to the blocks they address: the lock, unlock and lock-down results, the effect of toggling write protect on a block that was unlocked while locked down, the decoder's return to idle after a bad second byte, and the switching between the two read modes. A seeded random run of commands, protect levels and requests is compared against a bench model.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] CMD_SETUP    = 8'h60;
  localparam logic [CMD_W-1:0] CMD_LOCK     = 8'h01;
  localparam logic [CMD_W-1:0] CMD_UNLOCK   = 8'hD0;
  localparam logic [CMD_W-1:0] CMD_LOCKDOWN = 8'h2F;
  localparam logic [CMD_W-1:0] CMD_SIG      = 8'h90;
  localparam logic [CMD_W-1:0] CMD_ARRAY    = 8'hFF;

  typedef enum logic [1:0] {OP_NONE, OP_LOCK, OP_UNLOCK, OP_LOCKDOWN} lock_op_e;
  typedef enum logic {ST_IDLE, ST_SETUP} dec_state_e;
endpackage

// File: rtl/lock_cmd_dec.sv
module lock_cmd_dec
  import blk_lock_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [CMD_W-1:0] wr_data_i,
  output lock_op_e         op_o,
  output logic             sig_mode_o,
  output logic             seq_err_o
);
  dec_state_e state_q, state_d;
  logic       sig_q, sig_d;
  logic       err_d;

  always_comb begin
    state_d = state_q;
    sig_d   = sig_q;
    op_o    = OP_NONE;
    err_d   = 1'b0;
    if (wr_valid_i) begin
      if (state_q == ST_SETUP) begin
        state_d = ST_IDLE;
        unique case (wr_data_i)
          CMD_LOCK:     op_o = OP_LOCK;
          CMD_UNLOCK:   op_o = OP_UNLOCK;
          CMD_LOCKDOWN: op_o = OP_LOCKDOWN;
          default:      err_d = 1'b1;
        endcase
      end else begin
        unique case (wr_data_i)
          CMD_SETUP: state_d = ST_SETUP;
          CMD_SIG:   sig_d   = 1'b1;
          CMD_ARRAY: sig_d   = 1'b0;
          default:   ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sig_q     <= 1'b0;
      seq_err_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      sig_q     <= sig_d;
      seq_err_o <= err_d;
    end
  end

  assign sig_mode_o = sig_q;

  // R8
  seq_err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> ($past(state_q) == ST_SETUP && $past(wr_valid_i)));
  // R8
  seq_err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> state_q == ST_IDLE);
endmodule

// File: rtl/lock_state_array.sv
module lock_state_array
  import blk_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  lock_op_e              op_i,
  input  logic [BLK_W-1:0]      op_blk_i,
  input  logic                  wp_ni,
  output logic [NUM_BLOCKS-1:0] lk_eff_o,
  output logic [NUM_BLOCKS-1:0] ld_o
);
  logic [NUM_BLOCKS-1:0] lk_q, ld_q;

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
    localparam logic [BLK_W-1:0] IDX = BLK_W'(i);
    logic hit;
    assign hit = (op_blk_i == IDX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lk_q[i] <= 1'b1;
        ld_q[i] <= 1'b0;
      end else if (hit) begin
        unique case (op_i)
          OP_LOCK:     lk_q[i] <= 1'b1;
          OP_LOCKDOWN: begin lk_q[i] <= 1'b1; ld_q[i] <= 1'b1; end
          OP_UNLOCK:   if (!(ld_q[i] && !wp_ni)) lk_q[i] <= 1'b0;
          default:     ;
        endcase
      end
    end

    // locked-down forces locked while protect pin is low
    assign lk_eff_o[i] = lk_q[i] | (ld_q[i] & ~wp_ni);

    // R7
    ld_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_q[i] |=> ld_q[i]);
    // R5
    wp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_q[i] && lk_q[i] && !wp_ni) |=> lk_q[i]);
    // R4
    ld_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ld_q[i]) |-> lk_q[i]);
  end

  assign ld_o = ld_q;
endmodule

// File: rtl/lock_req_gate.sv
module lock_req_gate #(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [BLK_W-1:0]      req_blk_i,
  input  logic [NUM_BLOCKS-1:0] lk_eff_i,
  output logic                  permit_o,
  output logic                  prot_err_o
);
  logic blocked;
  assign blocked  = lk_eff_i[req_blk_i];
  assign permit_o = req_valid_i & ~blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prot_err_o <= 1'b0;
    else         prot_err_o <= req_valid_i & blocked;
  end

  // R10
  permit_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    permit_o |-> req_valid_i);
  // R10
  prot_err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_err_o |-> ($past(req_valid_i) && !$past(permit_o)));
endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
  import blk_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [BLK_W-1:0] wr_addr_i,
  input  logic [CMD_W-1:0] wr_data_i,
  input  logic             wp_ni,
  input  logic [BLK_W-1:0] query_blk_i,
  output logic [1:0]       status_o,
  output logic             sig_mode_o,
  input  logic             req_valid_i,
  input  logic [BLK_W-1:0] req_blk_i,
  output logic             req_permit_o,
  output logic             prot_err_o,
  output logic             seq_err_o
);
  lock_op_e              op;
  logic [NUM_BLOCKS-1:0] lk_eff, ld;

  lock_cmd_dec u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .op_o       (op),
    .sig_mode_o (sig_mode_o),
    .seq_err_o  (seq_err_o)
  );

  lock_state_array #(.NUM_BLOCKS(NUM_BLOCKS)) u_arr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .op_blk_i (wr_addr_i),
    .wp_ni    (wp_ni),
    .lk_eff_o (lk_eff),
    .ld_o     (ld)
  );

  lock_req_gate #(.NUM_BLOCKS(NUM_BLOCKS)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_blk_i   (req_blk_i),
    .lk_eff_i    (lk_eff),
    .permit_o    (req_permit_o),
    .prot_err_o  (prot_err_o)
  );

  assign status_o = sig_mode_o ? {ld[query_blk_i], lk_eff[query_blk_i]} : 2'b00;

  // R9
  status_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_mode_o |-> status_o == 2'b00);
endmodule

// File: tb/blk_lock_mgr_bench.sv
module blk_lock_mgr_bench;
  localparam int N = 16;
  localparam int BW = 4;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wp_n = 1, req_valid = 0;
  logic [BW-1:0] wr_addr = 0, query_blk = 0, req_blk = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] status;
  logic sig_mode, permit, prot_err, seq_err;

  int errors = 0, checks = 0;
  bit done = 0;
  bit exp_lk[N], exp_ld[N];
  bit exp_sig, exp_setup;

  always #10 clk = ~clk;

  blk_lock_mgr #(.NUM_BLOCKS(N)) u_blk_lock_mgr (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wp_ni(wp_n), .query_blk_i(query_blk), .status_o(status),
    .sig_mode_o(sig_mode), .req_valid_i(req_valid), .req_blk_i(req_blk),
    .req_permit_o(permit), .prot_err_o(prot_err), .seq_err_o(seq_err));

  function automatic bit eff(int b);
    return exp_lk[b] | (exp_ld[b] & ~wp_n);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin exp_lk[i] = 1; exp_ld[i] = 0; end
    exp_sig = 0; exp_setup = 0;
  endtask

  // returns expected seq_err
  function automatic bit model_wr(int a, logic [7:0] d);
    bit e = 0;
    if (exp_setup) begin
      exp_setup = 0;
      case (d)
        8'h01: exp_lk[a] = 1;
        8'h2F: begin exp_lk[a] = 1; exp_ld[a] = 1; end
        8'hD0: if (!(exp_ld[a] && !wp_n)) exp_lk[a] = 0;
        default: e = 1;
      endcase
    end else begin
      case (d)
        8'h60: exp_setup = 1;
        8'h90: exp_sig = 1;
        8'hFF: exp_sig = 0;
        default: ;
      endcase
    end
    return e;
  endfunction

  task automatic wr(int a, logic [7:0] d, string tag);
    bit e;
    @(negedge clk);
    wr_valid = 1; wr_addr = BW'(a); wr_data = d;
    e = model_wr(a, d);
    @(negedge clk);
    wr_valid = 0;
    chk({tag, " seq_err"}, seq_err, e);
  endtask

  task automatic q(int b, string tag);
    query_blk = BW'(b);
    #1;
    chk(tag, status, exp_sig ? {exp_ld[b], eff(b)} : 2'b00);
  endtask

  task automatic rq(int b, string tag);
    bit deny;
    @(negedge clk);
    req_valid = 1; req_blk = BW'(b);
    deny = eff(b);
    #1;
    chk({tag, " permit"}, permit, !deny);
    @(negedge clk);
    req_valid = 0;
    chk({tag, " prot_err"}, prot_err, deny);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1
    chk("R1 sig_mode", sig_mode, 0);
    q(0, "R1 array status");
    wr(0, 8'h90, "R9 enter");
    chk("R9 sig_mode", sig_mode, 1);
    for (int i = 0; i < N; i++) q(i, "R1 locked at reset");
    rq(3, "R10 deny locked");
    // R3
    wr(3, 8'h60, "R3"); wr(3, 8'hD0, "R3");
    q(3, "R3 unlocked"); q(4, "R2 neighbour untouched");
    rq(3, "R10 permit unlocked");
    // R2
    wr(3, 8'h60, "R2"); wr(3, 8'h01, "R2");
    q(3, "R2 relocked");
    // R4
    wr(5, 8'h60, "R4"); wr(5, 8'h2F, "R4");
    q(5, "R4 lockdown");
    // R5
    wp_n = 0;
    wr(5, 8'h60, "R5"); wr(5, 8'hD0, "R5");
    q(5, "R5 unlock ignored"); rq(5, "R5 deny");
    // R6
    wp_n = 1;
    wr(5, 8'h60, "R6"); wr(5, 8'hD0, "R6");
    q(5, "R6 unlocked while wp high"); rq(5, "R6 permit");
    wp_n = 0; #1;
    q(5, "R6 relocked by wp low"); rq(5, "R6 deny wp low");
    wp_n = 1;
    // R8
    wr(7, 8'h60, "R8"); wr(7, 8'hD0, "R8");
    wr(7, 8'h60, "R8"); wr(7, 8'h55, "R8 bad byte");
    q(7, "R8 state kept");
    @(negedge clk); chk("R8 pulse ends", seq_err, 0);
    wr(7, 8'h01, "R8 idle after error");
    q(7, "R8 no lock from idle");
    // R11
    wr(2, 8'h40, "R11"); wr(2, 8'hD0, "R11");
    chk("R11 sig kept", sig_mode, 1); q(2, "R11 state kept");
    // R9
    wr(0, 8'hFF, "R9 exit");
    chk("R9 array mode", sig_mode, 0); q(5, "R9 array status zero");
    wr(0, 8'h90, "R9 reenter");
    // R7
    wr(5, 8'h60, "R7"); wr(5, 8'h01, "R7");
    wr(5, 8'h60, "R7"); wr(5, 8'hD0, "R7");
    q(5, "R7 ld persists");
    do_reset();
    wr(0, 8'h90, "R7 post reset");
    q(5, "R7 ld cleared by reset");
    // random
    for (int it = 0; it < 400; it++) begin
      int b = int'($urandom_range(N - 1));
      int k = int'($urandom_range(9));
      wp_n = $urandom_range(1);
      case (k)
        0, 1, 2, 3: begin
          logic [7:0] d;
          case ($urandom_range(3))
            0: d = 8'h01; 1: d = 8'hD0; 2: d = 8'h2F; default: d = 8'h33;
          endcase
          wr(b, 8'h60, "R2 rnd setup"); wr(b, d, "R8 rnd second");
        end
        4: rq(b, "R10 rnd request");
        5: wr(b, 8'h12, "R11 rnd stray");
        default: q(b, "R6 rnd status");
      endcase
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule